// File: doc/BRIEF.md
# Partitioned SIMD Saturating Adder

A combinational 64-bit adder whose carry chain can be split into independent lanes. A two-bit lane-size select turns the 64-bit operands into eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or a single 64-bit word. All lanes are added at once. No carry passes from one lane into the next.

Each lane either wraps modulo its own width or, when saturation is enabled, clamps to the limit of its number range. A signed/unsigned select picks which range is used for clamping. In wrapping mode the signed select makes no difference. The block sits in a media datapath where vectors of small samples are added in one pass, for example when clipping audio or pixel values.

Top module: `simd_sat_adder`

## Requirements
- R1: `lane_mode_i` selects the lane size: 2'b00 gives eight 8-bit lanes, 2'b01 four 16-bit lanes, 2'b10 two 32-bit lanes and 2'b11 one 64-bit lane. Lane n occupies bits [n*w +: w] of the operands and of the result.
- R2: No carry crosses a lane boundary: the lowest bit of every lane is added with a carry-in of 0. Carries between bytes inside a wider lane do propagate.
- R3: With `sat_en_i` = 0, each lane of `sum_o` equals (a + b) mod 2^w, whatever the value of `signed_i`.
- R4: With `sat_en_i` = 1 and `signed_i` = 0, a lane whose unsigned sum carries out of its top bit yields all ones.
- R5: With `sat_en_i` = 1 and `signed_i` = 1, a lane whose operands are both non-negative and whose true sum exceeds 2^(w-1)-1 yields 0 followed by w-1 ones.
- R6: With `sat_en_i` = 1 and `signed_i` = 1, a lane whose operands are both negative and whose true sum is below -2^(w-1) yields 1 followed by w-1 zeros.
- R7: In saturating mode, a lane that does not overflow yields its exact sum. Each lane saturates on its own condition alone.
- R8: In 64-bit mode the full word carries through all 64 bits, and saturation applies to the whole word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 64 | First packed operand |
| b_i | input | 64 | Second packed operand |
| lane_mode_i | input | 2 | Lane size select (R1 encoding) |
| signed_i | input | 1 | 1: lanes are two's complement for clamping; 0: unsigned |
| sat_en_i | input | 1 | 1: clamp on overflow; 0: wrap |
| sum_o | output | 64 | Packed lane results |

## Verification
The block holds no state, so an internal fault shows at `sum_o` as soon as the inputs settle. A wrong lane mask lets a carry leak into the next lane, which sets a stray low bit at a lane boundary. It also attaches a saturation decision to the wrong lane, so clamped bytes appear in a lane that never overflowed. A wrong overflow term gives a result whose sign is flipped, or a wrapped result where a clamped one was due. The vectors are chosen so that every lane size meets a carry at each boundary, together with overflow in both directions, within the same operand pair.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
  typedef enum logic [1:0] {
    LANE_B8  = 2'b00,
    LANE_B16 = 2'b01,
    LANE_B32 = 2'b10,
    LANE_B64 = 2'b11
  } lane_mode_e;

  localparam int unsigned SEG_W_DEF   = 8;
  localparam int unsigned NUM_SEG_DEF = 8;
endpackage

// File: rtl/simd_lane_map.sv
module simd_lane_map #(
  parameter int unsigned NUM_SEG = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_SEG)
) (
  input  logic [1:0]                        lane_mode_i,
  output logic [NUM_SEG-1:0]                seg_first_o,
  output logic [NUM_SEG-1:0]                seg_last_o,
  output logic [NUM_SEG-1:0][IDX_W-1:0]     seg_top_o
);
  logic [IDX_W:0]   span_raw;
  logic [IDX_W-1:0] span_mask;

  always_comb begin
    span_raw = (IDX_W+1)'((1 << lane_mode_i) - 1);
    if (int'(span_raw) > NUM_SEG - 1) span_raw = (IDX_W+1)'(NUM_SEG - 1);
    span_mask = span_raw[IDX_W-1:0];
  end

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_map
    localparam logic [IDX_W-1:0] KI = IDX_W'(k);
    assign seg_first_o[k] = (KI & span_mask) == '0;
    assign seg_last_o[k]  = (KI & span_mask) == span_mask;
    assign seg_top_o[k]   = KI | span_mask;
  end

  // R1: lane count matches the selected size
  always_comb begin
    assert_lane_count_R1: assert ($countones(seg_last_o) == NUM_SEG / (int'(span_raw) + 1)
                                  && seg_first_o[0] && seg_last_o[NUM_SEG-1])
      else $error("lane map inconsistent");
  end
endmodule

// File: rtl/simd_seg_chain.sv
module simd_seg_chain #(
  parameter int unsigned NUM_SEG = 8,
  parameter int unsigned SEG_W   = 8,
  localparam int unsigned DATA_W = NUM_SEG * SEG_W
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [NUM_SEG-1:0] seg_first_i,
  output logic [DATA_W-1:0]  sum_o,
  output logic [NUM_SEG-1:0] seg_cout_o,
  output logic [NUM_SEG-1:0] seg_sovf_o
);
  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    logic             cin;
    logic             cout;
    logic [SEG_W:0]   ext;
    logic [SEG_W-1:0] sa, sb, ss;

    assign sa = a_i[k*SEG_W +: SEG_W];
    assign sb = b_i[k*SEG_W +: SEG_W];

    // carry is cut at every lane start
    if (k == 0) begin : g_lsb
      assign cin = 1'b0;
    end else begin : g_mid
      assign cin = seg_first_i[k] ? 1'b0 : g_seg[k-1].cout;
    end

    assign ext  = {1'b0, sa} + {1'b0, sb} + {{SEG_W{1'b0}}, cin};
    assign ss   = ext[SEG_W-1:0];
    assign cout = ext[SEG_W];

    assign sum_o[k*SEG_W +: SEG_W] = ss;
    assign seg_cout_o[k] = cout;
    // signed overflow if this segment were the top of its lane
    assign seg_sovf_o[k] = (sa[SEG_W-1] == sb[SEG_W-1]) && (ss[SEG_W-1] != sa[SEG_W-1]);

    // R2: a lane's low segment sees nothing from below
    always_comb begin
      if (seg_first_i[k]) begin
        assert_lane_isolated_R2: assert (sum_o[k*SEG_W +: SEG_W] == SEG_W'(sa + sb))
          else $error("carry leaked into lane start segment %0d", k);
      end
    end
  end
endmodule

// File: rtl/simd_sat_stage.sv
module simd_sat_stage #(
  parameter int unsigned NUM_SEG = 8,
  parameter int unsigned SEG_W   = 8,
  localparam int unsigned DATA_W = NUM_SEG * SEG_W,
  localparam int unsigned IDX_W  = $clog2(NUM_SEG)
) (
  input  logic [DATA_W-1:0]             a_i,
  input  logic [DATA_W-1:0]             sum_i,
  input  logic [NUM_SEG-1:0]            seg_cout_i,
  input  logic [NUM_SEG-1:0]            seg_sovf_i,
  input  logic [NUM_SEG-1:0][IDX_W-1:0] seg_top_i,
  input  logic                          signed_i,
  input  logic                          sat_en_i,
  output logic [DATA_W-1:0]             res_o
);
  localparam logic [SEG_W-1:0] ONES  = '1;
  localparam logic [SEG_W-1:0] ZEROS = '0;
  localparam logic [SEG_W-1:0] SMAX  = {1'b0, {(SEG_W-1){1'b1}}};
  localparam logic [SEG_W-1:0] SMIN  = {1'b1, {(SEG_W-1){1'b0}}};

  logic [NUM_SEG-1:0] a_msb;
  for (genvar j = 0; j < NUM_SEG; j++) begin : g_msb
    assign a_msb[j] = a_i[j*SEG_W + SEG_W - 1];
  end

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_clamp
    logic [IDX_W-1:0] top;
    logic             is_top, lane_ovf, lane_neg;
    logic [SEG_W-1:0] clamp;

    assign top      = seg_top_i[k];
    assign is_top   = (top == IDX_W'(k));
    assign lane_neg = a_msb[top];
    assign lane_ovf = sat_en_i & (signed_i ? seg_sovf_i[top] : seg_cout_i[top]);

    always_comb begin
      if (!signed_i)     clamp = ONES;
      else if (lane_neg) clamp = is_top ? SMIN : ZEROS;
      else               clamp = is_top ? SMAX : ONES;
    end

    assign res_o[k*SEG_W +: SEG_W] = lane_ovf ? clamp : sum_i[k*SEG_W +: SEG_W];
  end
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
  import simd_add_pkg::*;
#(
  parameter int unsigned NUM_SEG = NUM_SEG_DEF,
  parameter int unsigned SEG_W   = SEG_W_DEF,
  localparam int unsigned DATA_W = NUM_SEG * SEG_W,
  localparam int unsigned IDX_W  = $clog2(NUM_SEG)
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        lane_mode_i,
  input  logic              signed_i,
  input  logic              sat_en_i,
  output logic [DATA_W-1:0] sum_o
);
  logic [NUM_SEG-1:0]            seg_first, seg_last;
  logic [NUM_SEG-1:0][IDX_W-1:0] seg_top;
  logic [DATA_W-1:0]             raw_sum;
  logic [NUM_SEG-1:0]            seg_cout, seg_sovf;

  simd_lane_map #(.NUM_SEG(NUM_SEG)) u_map (
    .lane_mode_i (lane_mode_i),
    .seg_first_o (seg_first),
    .seg_last_o  (seg_last),
    .seg_top_o   (seg_top)
  );

  simd_seg_chain #(.NUM_SEG(NUM_SEG), .SEG_W(SEG_W)) u_chain (
    .a_i         (a_i),
    .b_i         (b_i),
    .seg_first_i (seg_first),
    .sum_o       (raw_sum),
    .seg_cout_o  (seg_cout),
    .seg_sovf_o  (seg_sovf)
  );

  simd_sat_stage #(.NUM_SEG(NUM_SEG), .SEG_W(SEG_W)) u_sat (
    .a_i        (a_i),
    .sum_i      (raw_sum),
    .seg_cout_i (seg_cout),
    .seg_sovf_i (seg_sovf),
    .seg_top_i  (seg_top),
    .signed_i   (signed_i),
    .sat_en_i   (sat_en_i),
    .res_o      (sum_o)
  );

  always_comb begin
    // R8: unpartitioned wrap equals a plain full-width add
    if (!sat_en_i && lane_mode_i == LANE_B64 && NUM_SEG == 8) begin
      assert_full_word_R8: assert (sum_o == DATA_W'(a_i + b_i))
        else $error("64-bit wrap mismatch");
    end
    for (int k = 0; k < NUM_SEG; k++) begin
      // R4: unsigned saturation never falls below either operand
      if (sat_en_i && !signed_i && lane_mode_i == LANE_B8) begin
        assert_u_floor_R4: assert (sum_o[k*SEG_W +: SEG_W] >= a_i[k*SEG_W +: SEG_W]
                                   && sum_o[k*SEG_W +: SEG_W] >= b_i[k*SEG_W +: SEG_W])
          else $error("unsigned clamp below operand, seg %0d", k);
      end
      // R5/R6: like-signed operands never produce an opposite-signed lane
      if (sat_en_i && signed_i && seg_last[k]
          && a_i[k*SEG_W + SEG_W - 1] == b_i[k*SEG_W + SEG_W - 1]) begin
        assert_sign_kept_R5_R6: assert (sum_o[k*SEG_W + SEG_W - 1] == a_i[k*SEG_W + SEG_W - 1])
          else $error("signed clamp flipped sign, seg %0d", k);
      end
    end
  end
endmodule

// File: tb/simd_sat_adder_tb.sv
module simd_sat_adder_tb_top;
  typedef struct packed {
    logic [63:0] a;
    logic [63:0] b;
    logic [1:0]  mode;
    logic        sgn;
    logic        sat;
    logic [63:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    // R3 bytes wrap, R2 no leak between bytes
    '{64'hFF80_7F01_0010_F0AA, 64'h0180_0101_0020_2055, 2'b00, 1'b0, 1'b0, 64'h0000_8002_0030_10FF, 4'd3},
    '{64'hFF80_7F01_0010_F0AA, 64'h0180_0101_0020_2055, 2'b00, 1'b1, 1'b0, 64'h0000_8002_0030_10FF, 4'd3},
    // R4
    '{64'hFF80_7F01_0010_F0AA, 64'h0180_0101_0020_2055, 2'b00, 1'b0, 1'b1, 64'hFFFF_8002_0030_FFFF, 4'd4},
    // R5/R6 bytes
    '{64'hFF80_7F01_0010_F0AA, 64'h0180_0101_0020_2055, 2'b00, 1'b1, 1'b1, 64'h0080_7F02_0030_10FF, 4'd5},
    // R2 carry inside 16-bit lanes
    '{64'hFFFF_7FFF_8000_00FF, 64'h0001_0001_8000_0001, 2'b01, 1'b0, 1'b0, 64'h0000_8000_0000_0100, 4'd2},
    '{64'hFFFF_7FFF_8000_00FF, 64'h0001_0001_8000_0001, 2'b01, 1'b1, 1'b1, 64'h0000_7FFF_8000_0100, 4'd6},
    '{64'hFFFF_7FFF_8000_00FF, 64'h0001_0001_8000_0001, 2'b01, 1'b0, 1'b1, 64'hFFFF_8000_FFFF_0100, 4'd4},
    // R1 32-bit lanes
    '{64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0001_0000_0001, 2'b10, 1'b0, 1'b0, 64'h0000_0000_8000_0000, 4'd1},
    '{64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0001_0000_0001, 2'b10, 1'b1, 1'b1, 64'h0000_0000_7FFF_FFFF, 4'd5},
    '{64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0001_0000_0001, 2'b10, 1'b0, 1'b1, 64'hFFFF_FFFF_8000_0000, 4'd4},
    '{64'h8000_0000_8000_0000, 64'h8000_0000_FFFF_FFFF, 2'b10, 1'b1, 1'b1, 64'h8000_0000_8000_0000, 4'd6},
    // R8 full word
    '{64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b11, 1'b0, 1'b0, 64'h8000_0000_0000_0000, 4'd8},
    '{64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b11, 1'b1, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 4'd8},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002, 2'b11, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 4'd8},
    // R7 no overflow: exact
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002, 2'b11, 1'b1, 1'b1, 64'h0000_0000_0000_0001, 4'd7},
    '{64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 1'b1, 1'b1, 64'h8000_0000_0000_0000, 4'd8},
    '{64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 1'b1, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 4'd3},
    '{64'h0102_0304_0506_0708, 64'h1010_1010_1010_1010, 2'b00, 1'b1, 1'b1, 64'h1112_1314_1516_1718, 4'd7}
  };

  logic        clk;
  logic        rst_ni;
  logic [63:0] a, b, sum;
  logic [1:0]  mode;
  logic        sgn, sat;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  simd_sat_adder dut_i (
    .a_i         (a),
    .b_i         (b),
    .lane_mode_i (mode),
    .signed_i    (sgn),
    .sat_en_i    (sat),
    .sum_o       (sum)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // lane-wise reference from integer ranges
  function automatic logic [63:0] model(logic [63:0] x, logic [63:0] y,
                                        logic [1:0] md, logic sg, logic st);
    logic [63:0] r = '0;
    int w = 8 << md;
    for (int l = 0; l < 64 / w; l++) begin
      logic [64:0] ux = '0, uy = '0, us;
      logic signed [66:0] sx, sy, ss, smax, smin;
      logic [64:0] lane;
      for (int i = 0; i < w; i++) begin
        ux[i] = x[l*w+i];
        uy[i] = y[l*w+i];
      end
      us = ux + uy;
      sx = $signed({2'b00, ux});
      sy = $signed({2'b00, uy});
      if (ux[w-1]) sx = sx - (67'sd1 <<< w);
      if (uy[w-1]) sy = sy - (67'sd1 <<< w);
      ss   = sx + sy;
      smax = (67'sd1 <<< (w-1)) - 67'sd1;
      smin = -(67'sd1 <<< (w-1));
      lane = us;
      if (st && !sg && us >= (65'd1 << w)) lane = (65'd1 << w) - 65'd1;
      if (st && sg && ss > smax) lane = 65'(smax);
      if (st && sg && ss < smin) lane = 65'(smin);
      for (int i = 0; i < w; i++) r[l*w+i] = lane[i];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] exp);
    n_chk++;
    if (sum !== exp) begin
      n_fail++;
      $display("FAIL %s: mode=%0d sgn=%0b sat=%0b got=%h exp=%h", tag, mode, sgn, sat, sum, exp);
    end
  endtask

  task automatic apply(logic [63:0] x, logic [63:0] y, logic [1:0] md, logic sg, logic st);
    @(negedge clk);
    a = x; b = y; mode = md; sgn = sg; sat = st;
    #1;
  endtask

  initial begin
    logic [63:0] lfsr_a, lfsr_b;
    a = '0; b = '0; mode = 2'b00; sgn = 1'b0; sat = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R3 zero operands in reset", 64'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].a, VECS[i].b, VECS[i].mode, VECS[i].sgn, VECS[i].sat);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].exp);
    end

    // R2: carry stops at lane edges for every mode
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'b00, 1'b0, 1'b0);
    check("R2 byte edges", 64'h0000_0000_0000_0000);
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 2'b01, 1'b0, 1'b0);
    check("R2 halfword edges", 64'h0);
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 2'b10, 1'b0, 1'b0);
    check("R2 word edges", 64'h0);
    // R7: one lane clamps, neighbour exact
    apply(64'h7F10_0000_0000_0000, 64'h0110_0000_0000_0000, 2'b00, 1'b1, 1'b1);
    check("R7 independent lanes", 64'h7F20_0000_0000_0000);

    // model sweep over all modes and flags
    lfsr_a = 64'hACE1_1234_5678_9ABC;
    lfsr_b = 64'h1357_9BDF_2468_ACE0;
    for (int i = 0; i < 512; i++) begin
      lfsr_a = {lfsr_a[62:0], lfsr_a[63] ^ lfsr_a[62] ^ lfsr_a[60] ^ lfsr_a[59]};
      lfsr_b = {lfsr_b[62:0], lfsr_b[63] ^ lfsr_b[62] ^ lfsr_b[60] ^ lfsr_b[59]};
      apply(lfsr_a, lfsr_b, i[1:0], i[2], i[3]);
      check("R1 R3 R4 R5 R6 sweep", model(lfsr_a, lfsr_b, i[1:0], i[2], i[3]));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got=timeout exp=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule